// File: doc/BRIEF.md
# Spare-Area Chunk Distributor for Flash Pages

This block places the spare (out-of-band) bytes of a flash page into a bank of small on-chip spare buffers. The page is split into 512-byte sectors, and each sector gets an equal, even-sized share of the spare bytes in its own buffer. Any spare bytes left over after the shares are handed out stay in the last buffer, after its normal share.

For each spare byte the sequencer gives the linear spare offset, counted from zero at the first spare byte after the main data. It raises a one-cycle valid strobe with the offset. The block returns the buffer number, the position inside that buffer's 64-byte window, and the full buffer RAM address. It also raises either a RAM write strobe, which captures an incoming flash byte during a page read, or a RAM read strobe, which fetches the outgoing byte during a program. Page size is given in bytes. Spare size is given in 16-bit words, as a configuration register holds it.

Top module: `spare_chunk_map`

## Requirements
- R1: After reset, ram_we, ram_re and map_err are 0.
- R2: The chunk count is page_size/512. The per-buffer share is (2*spare_words)/chunks, rounded down to an even number. For example, 4096/218 gives a share of 26.
- R3: buf_idx is offset/share, clamped to 7.
- R4: buf_ofs is offset minus buf_idx times share.
- R5: ram_addr is 0x1000 + buf_idx*0x40 + buf_ofs.
- R6: When dir_prog=0, ram_we is high for one cycle, one cycle after a valid strobe, and ram_wdata equals the flash byte given with the strobe.
- R7: When dir_prog=1, ram_re is high for one cycle, one cycle after a valid strobe, and ram_we stays 0.
- R8: If the in-buffer offset would be 64 or more, map_err is high for that cycle and neither RAM strobe is raised.
- R9: Without a valid strobe in the previous cycle, ram_we, ram_re and map_err are 0.
- R10: Remainder bytes stay in buffer 7. For 4096/218, offsets 182..217 map to buffer 7, positions 0..35.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| page_size | input | 13 | Main page size in bytes |
| spare_words | input | 8 | Spare size in 16-bit words |
| ofs_valid | input | 1 | Spare offset strobe |
| ofs | input | 8 | Linear spare byte offset |
| dir_prog | input | 1 | 0 = page read (fill buffer), 1 = program (fetch from buffer) |
| din | input | 8 | Flash byte on a page read |
| buf_idx | output | 3 | Selected spare buffer |
| buf_ofs | output | 6 | Position inside the buffer window |
| ram_addr | output | 13 | Buffer RAM byte address |
| ram_we | output | 1 | Buffer RAM write strobe |
| ram_re | output | 1 | Buffer RAM read strobe |
| ram_wdata | output | 8 | Byte to write into buffer RAM |
| map_err | output | 1 | Offset falls outside a buffer window |

## Verification
All results are due exactly one clock after the edge that samples ofs_valid. This covers the index, position, address, write data, the RAM strobes and the error flag. The bench drives each strobe on a falling edge and checks every output on the next falling edge, one rising edge later. It then drops the strobe and checks one more falling edge to confirm that the strobes and the error flag have returned to 0. Every offset from 0 to 255 is swept in both directions over the four supported page/spare shapes.

// File: rtl/spare_chunk_map.sv
module spare_chunk_map #(
  parameter int PAGE_W    = 13,
  parameter int SPW_W     = 8,
  parameter int OFS_W     = 8,
  parameter int DW        = 8,
  parameter int NBUF      = 8,
  parameter int WIN       = 64,
  parameter int SECTOR_LG = 9,
  parameter int ADDR_W    = 13,
  parameter int SPARE_BASE = 'h1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PAGE_W-1:0] page_size,
  input  logic [SPW_W-1:0]  spare_words,
  input  logic              ofs_valid,
  input  logic [OFS_W-1:0]  ofs,
  input  logic              dir_prog,
  input  logic [DW-1:0]     din,
  output logic [$clog2(NBUF)-1:0] buf_idx,
  output logic [$clog2(WIN)-1:0]  buf_ofs,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              ram_we,
  output logic              ram_re,
  output logic [DW-1:0]     ram_wdata,
  output logic              map_err
);
  localparam int IDX_W  = $clog2(NBUF);
  localparam int WO_W   = $clog2(WIN);
  localparam int SB_W   = SPW_W + 1;
  localparam int PROD_W = SB_W + IDX_W;
  localparam int SH_W   = $clog2(PAGE_W);

  logic [SH_W-1:0]   sh;
  logic [SB_W-1:0]   spare_bytes, per_raw, per;
  logic [NBUF-1:1]   ge;
  logic [IDX_W-1:0]  idx_c;
  logic [PROD_W-1:0] base, rel;
  logic              err_c;
  logic              unused_low;

  assign unused_low = ^page_size[SECTOR_LG-1:0];

  always_comb begin
    sh = '0;
    for (int b = SECTOR_LG; b < PAGE_W; b++)
      if (page_size[b]) sh = SH_W'(b - SECTOR_LG);
  end

  assign spare_bytes = {spare_words, 1'b0};
  assign per_raw     = spare_bytes >> sh;
  assign per         = {per_raw[SB_W-1:1], 1'b0};

  for (genvar k = 1; k < NBUF; k++) begin : g_cmp
    assign ge[k] = (per != '0) && (PROD_W'(ofs) >= PROD_W'(k) * PROD_W'(per));
  end

  always_comb begin
    idx_c = '0;
    for (int k = 1; k < NBUF; k++)
      if (ge[k]) idx_c = IDX_W'(k);
  end

  assign base  = PROD_W'(idx_c) * PROD_W'(per);
  assign rel   = PROD_W'(ofs) - base;
  assign err_c = (per == '0) || (rel >= PROD_W'(WIN));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_idx   <= '0;
      buf_ofs   <= '0;
      ram_we    <= 1'b0;
      ram_re    <= 1'b0;
      map_err   <= 1'b0;
      ram_wdata <= '0;
    end else begin
      ram_we  <= ofs_valid && !dir_prog && !err_c;
      ram_re  <= ofs_valid &&  dir_prog && !err_c;
      map_err <= ofs_valid && err_c;
      if (ofs_valid) begin
        buf_idx   <= idx_c;
        buf_ofs   <= rel[WO_W-1:0];
        ram_wdata <= din;
      end
    end
  end

  assign ram_addr = ADDR_W'(SPARE_BASE) + ADDR_W'(buf_idx) * ADDR_W'(WIN) + ADDR_W'(buf_ofs);

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ofs_valid |=> !(ram_we || ram_re || map_err));
  p_one_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(ram_we && ram_re));
  p_err_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    map_err |-> !(ram_we || ram_re));
  p_read_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ofs_valid && !dir_prog) |=> ((ram_we || map_err) && ram_wdata == $past(din)));
  p_prog_fetch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ofs_valid && dir_prog) |=> ((ram_re || map_err) && !ram_we));
endmodule

// File: tb/spare_chunk_map_tb.sv
module spare_chunk_map_tb;
  logic        clk = 0, rst_n = 0;
  logic [12:0] page_size = 13'd512;
  logic [7:0]  spare_words = 8'd8;
  logic        ofs_valid = 0, dir_prog = 0;
  logic [7:0]  ofs = 0, din = 0;
  logic [2:0]  buf_idx;
  logic [5:0]  buf_ofs;
  logic [12:0] ram_addr;
  logic        ram_we, ram_re, map_err;
  logic [7:0]  ram_wdata;
  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  spare_chunk_map u_dut (
    .clk(clk), .rst_n(rst_n), .page_size(page_size), .spare_words(spare_words),
    .ofs_valid(ofs_valid), .ofs(ofs), .dir_prog(dir_prog), .din(din),
    .buf_idx(buf_idx), .buf_ofs(buf_ofs), .ram_addr(ram_addr),
    .ram_we(ram_we), .ram_re(ram_re), .ram_wdata(ram_wdata), .map_err(map_err));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_cfg(input int psz, input int sw);
    int chunks, per;
    chunks = psz / 512;
    per = ((sw * 2) / chunks) & ~1;
    page_size = 13'(psz);
    spare_words = 8'(sw);
    for (int d = 0; d < 2; d++) begin
      for (int o = 0; o < 256; o++) begin
        int idx, rel, addr;
        bit err;
        idx = o / per; if (idx > 7) idx = 7;
        rel = o - idx * per;
        err = (rel >= 64);
        addr = 'h1000 + idx * 64 + rel;
        @(negedge clk);
        ofs_valid = 1; ofs = 8'(o); dir_prog = d[0]; din = 8'((o * 7 + d * 91) & 255);
        @(negedge clk);
        ofs_valid = 0;
        if (err) begin
          check(map_err == 1, "R8 err flag", map_err, 1);
          check(!ram_we && !ram_re, "R8 no strobe", {ram_we, ram_re}, 0);
        end else begin
          check(map_err == 0, "R8 no err", map_err, 0);
          if (o == per) check(buf_idx == 1 && buf_ofs == 0, "R2 share boundary", buf_idx, 1);
          if (psz == 4096 && sw == 109 && o >= 182)
            check(buf_idx == 7 && buf_ofs == 6'(o - 182), "R10 remainder", buf_ofs, o - 182);
          check(buf_idx == 3'(idx), "R3 index", buf_idx, idx);
          check(buf_ofs == 6'(rel), "R4 position", buf_ofs, rel);
          check(ram_addr == 13'(addr), "R5 address", ram_addr, addr);
          if (d == 0) begin
            check(ram_we && !ram_re, "R6 write strobe", {ram_we, ram_re}, 2);
            check(ram_wdata == din, "R6 write data", ram_wdata, din);
          end else begin
            check(ram_re && !ram_we, "R7 read strobe", {ram_we, ram_re}, 1);
          end
        end
        @(negedge clk);
        check(!ram_we && !ram_re && !map_err, "R9 idle", {ram_we, ram_re, map_err}, 0);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!ram_we && !ram_re && !map_err, "R1 reset", {ram_we, ram_re, map_err}, 0);
    rst_n = 1;
    @(negedge clk);
    check(!ram_we && !ram_re && !map_err, "R1 after release", {ram_we, ram_re, map_err}, 0);
    run_cfg(512, 8);
    run_cfg(2048, 32);
    run_cfg(4096, 64);
    run_cfg(4096, 109);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule